// File: doc/BRIEF.md
# TDM Channel Start and Timeslot Aligner

This block decides when one channel starts moving data on a serial time-division frame of 32 slots. It also decides which slot carries the channel's first buffer byte. The bench or the surrounding logic steps a slot counter once per clock, with slot 0 first in each frame, and drives a bit mask of the slots that belong to the channel. The block returns three outputs: a running flag, a per-slot byte-enable, and a one-cycle strobe that marks where buffer byte 0 is sent or received. Transmit and receive both use the same strobe.

A channel can be started in one of two modes. A packet-mode channel (HDLC) starts on the clock after activation and takes no account of frame boundaries. Its first byte falls in whichever mapped slot comes up first. A transparent-mode channel waits for a frame sync before it starts. A select bit chooses whether that sync comes from the internal frame pulse or from the external sync input. In transparent mode, byte 0 lands on the lowest mapped slot, but slot 0 is never used as the start. Mapped slots that come before the start slot are not enabled. Once byte 0 has passed, every mapped slot carries a byte, frame after frame, and later sync pulses cause no realignment. The channel keeps running until it is deactivated.

Top module: `tdm_slot_aligner`

## Requirements
- R1: While reset is low, and in the first cycle after it, running, byteEn and firstByte are all 0.
- R2: With modeTransparent=0, running is 1 in the cycle after an activate pulse, whatever the sync inputs do.
- R3: With modeTransparent=1, running stays 0 after an activate pulse until the selected sync is seen. Running becomes 1 in the cycle after that sync.
- R4: syncSelExt=1 at activation selects extSync as the start sync and syncSelExt=0 selects intSync. Pulses on the unselected input do not start the channel.
- R5: In transparent mode, firstByte goes high in the first occurrence of the lowest set mask bit among slots 1..31. For a mask of slots 0 and 1, that is slot 1.
- R6: In transparent mode, a mask that has only slot 0 set never produces firstByte and never produces byteEn.
- R7: After byte 0, byteEn is 1 exactly in the cycles whose slotNum has its mask bit set, across frame wraps. Sync pulses that arrive while running change nothing.
- R8: In HDLC mode, firstByte goes high in the first mapped slot reached after running rises. That slot may be slot 0.
- R9: deactivate clears running in the next cycle. When it arrives in the same cycle as activate, deactivate wins.
- R10: A sync pulse in the same cycle as the activate pulse does not start a transparent channel. The channel waits for the next selected sync.
- R11: firstByte is high in at most one cycle per activation, and only in a cycle where byteEn is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| activate | input | 1 | One-cycle channel start request |
| deactivate | input | 1 | One-cycle channel stop request |
| modeTransparent | input | 1 | 1 = transparent, 0 = HDLC; sampled on activate |
| syncSelExt | input | 1 | 1 = start on extSync, 0 = on intSync; sampled on activate |
| intSync | input | 1 | Internal frame pulse, high during slot 0 |
| extSync | input | 1 | External frame pulse, high during slot 0 |
| slotMask | input | 32 | Bit n set = slot n belongs to the channel |
| slotNum | input | 5 | Current slot number |
| running | output | 1 | Channel is processing data |
| byteEn | output | 1 | Current slot carries a channel byte |
| firstByte | output | 1 | Current slot carries buffer byte 0 |

## Verification
Two events can land in the same cycle: the activate pulse and the start sync. The bench provokes this by raising activate exactly in the slot-0 cycle, while the internal sync pulse is high. A correct block ignores that pulse, keeps running low for the rest of the frame, and starts only on the next frame's sync. A per-cycle behavioural model predicts exactly that, and directed checks confirm running before and after the following frame. The same scheme covers deactivate colliding with activate: running must remain low afterwards.

// File: rtl/tsa_pkg.sv
`timescale 1ns/1ps
package tsa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } tsaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // new activation accepted this cycle
    logic run;        // channel is running
    logic alignMode;  // transparent alignment in force
  } tsaCtrl_s;

endpackage

// File: rtl/tsa_ctrl.sv
`timescale 1ns/1ps
module tsa_ctrl
  import tsa_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     activate,
  input  logic     deactivate,
  input  logic     modeTransparent,
  input  logic     syncSelExt,
  input  logic     intSync,
  input  logic     extSync,
  output tsaCtrl_s ctrlOut
);

  tsaState_e state;
  logic      modeQ;
  logic      selQ;
  logic      syncHit;

  // only the source chosen at activation may start the channel
  assign syncHit = selQ ? extSync : intSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      modeQ <= 1'b0;
      selQ  <= 1'b0;
    end else if (deactivate) begin
      state <= ST_IDLE;
    end else if (activate) begin
      state <= modeTransparent ? ST_WAIT : ST_RUN;
      modeQ <= modeTransparent;
      selQ  <= syncSelExt;
    end else if (state == ST_WAIT && syncHit) begin
      state <= ST_RUN;
    end
  end

  always_comb begin
    ctrlOut.load      = activate && !deactivate;
    ctrlOut.run       = (state == ST_RUN);
    ctrlOut.alignMode = modeQ;
  end

endmodule

// File: rtl/tsa_datapath.sv
`timescale 1ns/1ps
module tsa_datapath
  import tsa_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tsaCtrl_s             ctrlIn,
  input  logic [NUM_SLOTS-1:0] slotMask,
  input  logic [SLOT_W-1:0]    slotNum,
  output logic                 byteEn,
  output logic                 firstByte
);

  logic [SLOT_W-1:0] startSlot;
  logic              startValid;
  logic              pend;
  logic              slotHit;
  logic              startOk;

  // lowest mapped slot above slot 0; scanning downward leaves the lowest
  always_comb begin
    startSlot  = '0;
    startValid = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 1; i--) begin
      if (slotMask[i]) begin
        startSlot  = SLOT_W'(i);
        startValid = 1'b1;
      end
    end
  end

  assign slotHit = slotMask[slotNum];

  always_comb begin
    if (ctrlIn.alignMode) startOk = startValid && (slotNum == startSlot);
    else                  startOk = 1'b1;
  end

  // byte 0 still owed for this activation
  always_ff @(posedge clk) begin
    if (!rstN)            pend <= 1'b0;
    else if (ctrlIn.load) pend <= 1'b1;
    else if (firstByte)   pend <= 1'b0;
  end

  assign byteEn    = ctrlIn.run && slotHit && (!pend || startOk);
  assign firstByte = byteEn && pend;

endmodule

// File: rtl/tdm_slot_aligner.sv
`timescale 1ns/1ps
module tdm_slot_aligner
  import tsa_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 activate,
  input  logic                 deactivate,
  input  logic                 modeTransparent,
  input  logic                 syncSelExt,
  input  logic                 intSync,
  input  logic                 extSync,
  input  logic [NUM_SLOTS-1:0] slotMask,
  input  logic [SLOT_W-1:0]    slotNum,
  output logic                 running,
  output logic                 byteEn,
  output logic                 firstByte
);

  tsaCtrl_s ctrl;

  tsa_ctrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .activate        (activate),
    .deactivate      (deactivate),
    .modeTransparent (modeTransparent),
    .syncSelExt      (syncSelExt),
    .intSync         (intSync),
    .extSync         (extSync),
    .ctrlOut         (ctrl)
  );

  tsa_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlIn    (ctrl),
    .slotMask  (slotMask),
    .slotNum   (slotNum),
    .byteEn    (byteEn),
    .firstByte (firstByte)
  );

  assign running = ctrl.run;

endmodule

// File: rtl/tsa_checker.sv
`timescale 1ns/1ps
module tsa_checker #(
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              activate,
  input logic              deactivate,
  input logic              modeTransparent,
  input logic [SLOT_W-1:0] slotNum,
  input logic              running,
  input logic              byteEn,
  input logic              firstByte
);

  logic modeSeen;
  logic seenFirst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSeen  <= 1'b0;
      seenFirst <= 1'b0;
    end else if (activate && !deactivate) begin
      modeSeen  <= modeTransparent;
      seenFirst <= 1'b0;
    end else if (firstByte) begin
      seenFirst <= 1'b1;
    end
  end

  AST_DEACT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    deactivate |=> !running); // R9
  AST_HDLC_START: assert property (@(posedge clk) disable iff (!rstN)
    (activate && !deactivate && !modeTransparent) |=> running); // R2
  AST_TRANSP_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (activate && !deactivate && modeTransparent) |=> !running); // R3
  AST_FIRST_WITH_EN: assert property (@(posedge clk) disable iff (!rstN)
    firstByte |-> byteEn); // R11
  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    firstByte |-> !seenFirst); // R11
  AST_FIRST_NOT_SLOT0: assert property (@(posedge clk) disable iff (!rstN)
    (firstByte && modeSeen) |-> (slotNum != '0)); // R5
  AST_EN_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    byteEn |-> running); // R7

endmodule

bind tdm_slot_aligner tsa_checker #(.SLOT_W(SLOT_W)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .activate        (activate),
  .deactivate      (deactivate),
  .modeTransparent (modeTransparent),
  .slotNum         (slotNum),
  .running         (running),
  .byteEn          (byteEn),
  .firstByte       (firstByte)
);

// File: tb/tb_tdm_slot_aligner.sv
`timescale 1ns/1ps
module tb_tdm_slot_aligner;

  logic        clk = 1'b0;
  logic        rstN;
  logic        act, deact, modeT, selExt, iSync, eSync;
  logic [31:0] mask;
  logic [4:0]  slot;
  logic        running, byteEn, firstByte;

  always #2.5 clk = ~clk;

  tdm_slot_aligner dut (
    .clk(clk), .rstN(rstN), .activate(act), .deactivate(deact),
    .modeTransparent(modeT), .syncSelExt(selExt), .intSync(iSync),
    .extSync(eSync), .slotMask(mask), .slotNum(slot),
    .running(running), .byteEn(byteEn), .firstByte(firstByte)
  );

  int checks = 0;
  int errors = 0;
  int slotCnt = 0;
  bit intOn = 0, extOn = 0;
  // reference model state
  int mState = 0;       // 0 idle, 1 waiting, 2 running
  bit mModeT = 0, mExt = 0, mPend = 0;
  // observations
  int firstCount = 0, lastFirstSlot = -1, enCount = 0;
  bit lastRun = 0;

  task automatic chk(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (slot %0d)", tag, actual, expected, slotCnt);
    end
  endtask

  function automatic int lowestStart(logic [31:0] m);
    int q[$];
    for (int i = 1; i < 32; i++) if (m[i]) q.push_back(i);
    return (q.size() == 0) ? -1 : q[0];
  endfunction

  task automatic step();
    bit eRun, eEn, eFb, st, syncSel;
    slot  = slotCnt[4:0];
    iSync = intOn && (slotCnt == 0);
    eSync = extOn && (slotCnt == 0);
    #1;
    eRun = (mState == 2);
    st   = mModeT ? (lowestStart(mask) == slotCnt) : 1'b1;
    eEn  = eRun && mask[slotCnt] && (!mPend || st);
    eFb  = eEn && mPend;
    chk("R3 running", int'(running), int'(eRun));
    chk("R7 byteEn", int'(byteEn), int'(eEn));
    chk("R5 firstByte", int'(firstByte), int'(eFb));
    if (firstByte) begin firstCount++; lastFirstSlot = slotCnt; end
    if (byteEn) enCount++;
    @(posedge clk);
    syncSel = mExt ? eSync : iSync;
    if (deact) mState = 0;
    else if (act) begin
      mState = modeT ? 1 : 2; mModeT = modeT; mExt = selExt;
    end else if (mState == 1 && syncSel) mState = 2;
    if (act && !deact) mPend = 1;
    else if (eFb) mPend = 0;
    @(negedge clk);
    lastRun = running;
    slotCnt = (slotCnt + 1) % 32;
    act = 0; deact = 0;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic runUntilFirst(int maxSteps);
    for (int i = 0; i < maxSteps; i++) begin
      step();
      if (firstCount != 0) break;
    end
  endtask

  task automatic startChan(bit t, bit ext, logic [31:0] m, int atSlot);
    deact = 1; step();
    mask = m;
    while (slotCnt != atSlot) step();
    modeT = t; selExt = ext; act = 1;
    firstCount = 0; lastFirstSlot = -1; enCount = 0;
    step();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; act = 0; deact = 0; modeT = 0; selExt = 0;
    iSync = 0; eSync = 0; mask = '0; slot = '0;
    repeat (3) @(negedge clk);
    chk("R1 running in reset", int'(running), 0);
    chk("R1 byteEn in reset", int'(byteEn), 0);
    chk("R1 firstByte in reset", int'(firstByte), 0);
    rstN = 1;
    step();

    // transparent, internal sync, slots 12,13,20, activate mid-frame
    intOn = 1;
    startChan(1, 0, (32'h1 << 12) | (32'h1 << 13) | (32'h1 << 20), 5);
    chk("R3 waits after activate", int'(lastRun), 0);
    runUntilFirst(80);
    chk("R5 first slot lowest mapped", lastFirstSlot, 12);
    enCount = 0;
    steps(64);
    chk("R7 bytes in two frames", enCount, 6);
    chk("R11 single first byte", firstCount, 1);

    // slots 0 and 1: start skips slot 0
    startChan(1, 0, 32'h3, 7);
    runUntilFirst(80);
    chk("R5 slot0 skipped as start", lastFirstSlot, 1);

    // slot 0 only: never starts a byte stream
    startChan(1, 0, 32'h1, 3);
    steps(96);
    chk("R6 no first byte", firstCount, 0);
    chk("R6 no byte enable", enCount, 0);

    // HDLC, slots 0 and 3, activate at slot 20, no syncs at all
    intOn = 0;
    startChan(0, 0, 32'h9, 20);
    chk("R2 running next cycle", int'(lastRun), 1);
    runUntilFirst(40);
    chk("R8 first mapped slot reached", lastFirstSlot, 0);

    // external select: internal pulses must not start it
    intOn = 1; extOn = 0;
    startChan(1, 1, 32'h1 << 5, 10);
    steps(40);
    chk("R4 internal sync ignored", int'(lastRun), 0);
    extOn = 1;
    runUntilFirst(80);
    chk("R4 external sync starts", lastFirstSlot, 5);
    extOn = 0;

    // activate coincides with internal sync at slot 0
    startChan(1, 0, 32'h1 << 4, 0);
    chk("R10 same-cycle sync not used", int'(lastRun), 0);
    steps(20);
    chk("R10 still waiting", int'(lastRun), 0);
    steps(20);
    chk("R10 starts next frame", int'(lastRun), 1);

    // sync pulses while running are ignored (model compares each cycle)
    steps(64);
    chk("R7 no realignment", firstCount, 1);

    // deactivate wins over activate
    deact = 1; act = 1; modeT = 0;
    step();
    chk("R9 deactivate wins", int'(lastRun), 0);
    steps(3);
    chk("R9 stays idle", int'(lastRun), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule